// File: doc/BRIEF.md
# Descriptor Staging and Commit Queue

This block is the write-side front end of a scatter-gather transfer engine. Software writes the eight 32-bit words of a transfer descriptor through a narrow register port. The port carries a word offset and no byte enables. Each word lands in a staging register. Nothing reaches the queue until the control word is written with its commit bit set. That one write moves the seven staged words and the control word being written into the queue as a single entry. Software can therefore fill the other words in any order and repeat only the fields that change between descriptors.

The queue side gives the whole 256-bit descriptor to a downstream engine through a valid/ready handshake. Full and empty flags and a 16-bit fill count go out to a separate status block. Software polls the full flag before it starts a new descriptor. A commit that arrives when no entry is free is discarded and reported with a one-cycle pulse.

Top module: `dsc_commit_port`

## Requirements
- R1: After reset, `desc_valid_o` is 0, `q_empty_o` is 1, `q_full_o` is 0, `q_level_o` is 0 and `commit_drop_o` is 0.
- R2: A write to offsets 0 to 6, or a write to offset 7 with bit 31 clear, only updates the staging register at that offset. The queue level and `desc_valid_o` stay unchanged.
- R3: A write to offset 7 with bit 31 set, with the queue not full, appends one entry. In that entry, word k sits at bits 32k+31..32k. Words 0 to 6 are the staged values and word 7 is the written control word, bit 31 included. The entry is visible at the outputs in the cycle after the write.
- R4: Staged words survive a commit. A later commit that writes only the control word repeats the earlier words 0 to 6.
- R5: The order in which words 0 to 6 are written does not matter. When one offset is written more than once before a commit, the last write wins.
- R6: Entries leave the queue in the order they were committed.
- R7: `q_level_o` equals the number of stored entries, from 0 to DEPTH. `q_full_o` is 1 exactly when the level is DEPTH, and `q_empty_o` is 1 exactly when the level is 0.
- R8: An entry is removed at a clock edge where `desc_valid_o` and `desc_ready_i` are both 1. `desc_valid_o` is 1 exactly when the queue is not empty. When the queue is empty, `desc_ready_i` has no effect.
- R9: A commit while the queue is full is dropped. `commit_drop_o` is 1 for exactly the cycle after it and 0 otherwise. The staged words are kept.
- R10: A commit and a pop at the same edge on a queue that is not full leave the level unchanged. The popped entry is the older one.
- R11: Fullness is judged before the pop at the same edge. A commit that coincides with a pop from a full queue is dropped, and the level falls by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Word offset (7 = control word) |
| wr_data_i | input | 32 | Write data |
| desc_valid_o | output | 1 | Queue head is valid |
| desc_ready_i | input | 1 | Downstream accepts the head |
| desc_data_o | output | 256 | Head descriptor, word k at bits 32k+31..32k |
| q_full_o | output | 1 | No free entry |
| q_empty_o | output | 1 | No stored entry |
| q_level_o | output | 16 | Number of stored entries |
| commit_drop_o | output | 1 | One-cycle pulse for a discarded commit |

## Verification
Every result of a write or a handshake is registered once, so the level, the flags, the head descriptor and the drop pulse all change at the edge that samples the stimulus. They are due in the cycle after it. The bench drives each stimulus on a falling edge and checks it one falling edge later, after the single register stage. It reads the data being popped on the falling edge before the handshake edge. The bench sweeps every fill level from empty to full against every combination of commit and pop, and compares each outcome with a queue model kept in the bench.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_WORDS  = 8;
  localparam int unsigned DESC_W     = WORD_W * NUM_WORDS;
  localparam int unsigned ADDR_W     = $clog2(NUM_WORDS);
  localparam int unsigned CTRL_IDX   = NUM_WORDS - 1;
  localparam int unsigned COMMIT_BIT = WORD_W - 1;
  localparam int unsigned LEVEL_W    = 16;
  typedef logic [DESC_W-1:0] desc_t;
endpackage

// File: rtl/dsc_stage.sv
module dsc_stage
  import dsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              commit_o,
  output desc_t             desc_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (wr_addr_i == ADDR_W'(i)) word_q[i] <= wr_data_i;
    end
  end

  assign commit_o = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_IDX)) && wr_data_i[COMMIT_BIT];

  // control word comes straight from the bus so the commit write itself is enqueued
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++)
      desc_o[i*WORD_W +: WORD_W] = (i == CTRL_IDX) ? wr_data_i : word_q[i];
  end
endmodule

// File: rtl/dsc_fifo.sv
module dsc_fifo #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned WIDTH   = 256,
  parameter int unsigned LEVEL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [WIDTH-1:0]   data_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [WIDTH-1:0]   data_o,
  output logic               full_o,
  output logic               empty_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic               drop_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drop_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign valid_o = !empty_o;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      drop_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CNT_W'(1);
      drop_q <= push_i && full_o;
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = LEVEL_W'(cnt_q);
  assign drop_o  = drop_q;
endmodule

// File: rtl/dsc_commit_port.sv
module dsc_commit_port
  import dsc_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [31:0]         wr_data_i,
  output logic                desc_valid_o,
  input  logic                desc_ready_i,
  output logic [255:0]        desc_data_o,
  output logic                q_full_o,
  output logic                q_empty_o,
  output logic [15:0]         q_level_o,
  output logic                commit_drop_o
);
  logic  commit;
  desc_t staged;

  dsc_stage u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .commit_o  (commit),
    .desc_o    (staged)
  );

  dsc_fifo #(.DEPTH(DEPTH), .WIDTH(DESC_W), .LEVEL_W(LEVEL_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (commit),
    .data_i  (staged),
    .ready_i (desc_ready_i),
    .valid_o (desc_valid_o),
    .data_o  (desc_data_o),
    .full_o  (q_full_o),
    .empty_o (q_empty_o),
    .level_o (q_level_o),
    .drop_o  (commit_drop_o)
  );
endmodule

// File: rtl/dsc_commit_port_chk.sv
module dsc_commit_port_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [2:0]   wr_addr_i,
  input logic [31:0]  wr_data_i,
  input logic         desc_valid_o,
  input logic         desc_ready_i,
  input logic [255:0] desc_data_o,
  input logic         q_full_o,
  input logic         q_empty_o,
  input logic [15:0]  q_level_o,
  input logic         commit_drop_o
);
  logic commit, pop;
  assign commit = wr_en_i && (wr_addr_i == 3'd7) && wr_data_i[31];
  assign pop    = desc_valid_o && desc_ready_i;

  p_level_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_level_o <= 16'(DEPTH));

  p_empty_no_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_empty_o |-> !desc_valid_o);

  p_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !q_full_o && !pop) |=> (q_level_o == $past(q_level_o) + 16'd1));

  p_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !commit) |=> (q_level_o == $past(q_level_o) - 16'd1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !pop) |=> $stable(q_level_o));

  p_push_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && pop && !q_full_o) |=> $stable(q_level_o));

  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && q_full_o) |=> commit_drop_o);

  p_no_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && q_full_o) |=> !commit_drop_o);

  p_full_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && q_full_o && desc_ready_i) |=> (q_level_o == $past(q_level_o) - 16'd1));
endmodule

bind dsc_commit_port dsc_commit_port_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/dsc_commit_port_tb.sv
module dsc_commit_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rdy = 1'b0;
  logic         valid, full, empty, drop;
  logic [255:0] data;
  logic [15:0]  level;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0]  stg [8];
  logic [255:0] q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsc_commit_port #(.DEPTH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .desc_valid_o(valid), .desc_ready_i(rdy),
    .desc_data_o(data), .q_full_o(full), .q_empty_o(empty),
    .q_level_o(level), .commit_drop_o(drop)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wv(input int n, input int i);
    return {8'(n), 8'(i), 16'h5a00 + 16'(n * 7 + i)};
  endfunction

  function automatic logic [31:0] cw(input int n);
    logic [31:0] v = wv(n, 7);
    return {1'b1, v[30:0]};
  endfunction

  // drive on falling edge, model the edge, check one falling edge later
  task automatic step(input logic en, input logic [2:0] a, input logic [31:0] d, input logic r);
    logic [255:0] e;
    bit commit, was_full, pop_ok;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; rdy = r;
    commit   = en && a == 3'd7 && d[31];
    was_full = (q.size() == N);
    pop_ok   = r && q.size() != 0;
    if (pop_ok) begin
      chk("R6 pop data", data, q[0]);
      void'(q.pop_front());
    end
    for (int i = 0; i < 7; i++) e[i*32 +: 32] = stg[i];
    e[255:224] = d;
    if (en) stg[a] = d;
    if (commit && !was_full) q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0; rdy = 1'b0;
    chk("R7 level", 256'(level), 256'(q.size()));
    chk("R7 full", 256'(full), 256'(q.size() == N));
    chk("R7 empty", 256'(empty), 256'(q.size() == 0));
    chk("R8 valid", 256'(valid), 256'(q.size() != 0));
    chk("R9 drop", 256'(drop), 256'(commit && was_full));
    if (q.size() != 0) chk("R6 head", data, q[0]);
  endtask

  task automatic load(input int n);
    for (int i = 6; i >= 0; i--) step(1'b1, 3'(i), wv(n, i), 1'b0);
  endtask

  task automatic drain();
    while (q.size() != 0) step(1'b0, 3'd0, 32'd0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [255:0] e;
    for (int i = 0; i < 8; i++) stg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 256'(valid), 256'(0));
    chk("R1 empty", 256'(empty), 256'(1));
    chk("R1 full", 256'(full), 256'(0));
    chk("R1 level", 256'(level), 256'(0));
    chk("R1 drop", 256'(drop), 256'(0));
    rst_n = 1'b1;

    // R2 staging writes and uncommitted control do not push
    load(1);
    step(1'b1, 3'd7, 32'h1234_5678, 1'b0);
    chk("R2 level", 256'(level), 256'(0));
    chk("R2 valid", 256'(valid), 256'(0));

    // R5 last write wins, arbitrary order
    step(1'b1, 3'd2, 32'hdead_beef, 1'b0);
    step(1'b1, 3'd0, 32'h0bad_f00d, 1'b0);
    step(1'b1, 3'd2, 32'hcafe_0002, 1'b0);
    step(1'b1, 3'd7, cw(1), 1'b0);
    chk("R5 word2", 256'(data[95:64]), 256'(32'hcafe_0002));
    chk("R5 word0", 256'(data[31:0]), 256'(32'h0bad_f00d));
    // R3 layout of committed entry
    for (int i = 0; i < 8; i++) e[i*32 +: 32] = (i == 7) ? cw(1) : stg[i];
    chk("R3 entry", data, e);
    chk("R3 level", 256'(level), 256'(1));

    // R4 control-only commit repeats staged words
    step(1'b1, 3'd7, cw(2), 1'b0);
    chk("R4 level", 256'(level), 256'(2));
    drain();
    chk("R4 drained", 256'(level), 256'(0));

    // fill to full, then overflow
    for (int n = 10; n < 10 + N; n++) begin
      load(n);
      step(1'b1, 3'd7, cw(n), 1'b0);
    end
    chk("R7 full at depth", 256'(full), 256'(1));
    step(1'b1, 3'd7, cw(99), 1'b0);
    chk("R9 dropped", 256'(drop), 256'(1));
    chk("R9 level", 256'(level), 256'(N));
    step(1'b0, 3'd0, 32'd0, 1'b0);
    chk("R9 pulse ends", 256'(drop), 256'(0));
    drain();
    // R9 staged words kept after drop: control-only commit reuses words of n=10+N-1
    step(1'b1, 3'd7, cw(50), 1'b0);
    chk("R9 kept word3", 256'(data[127:96]), 256'(wv(10 + N - 1, 3)));
    drain();

    // R8 ready while empty
    step(1'b0, 3'd0, 32'd0, 1'b1);
    chk("R8 empty ready", 256'(level), 256'(0));

    // R10 simultaneous push and pop
    load(60); step(1'b1, 3'd7, cw(60), 1'b0);
    e = data;
    load(61); step(1'b1, 3'd7, cw(61), 1'b1);
    chk("R10 level", 256'(level), 256'(1));
    chk("R10 head is newer", 256'(data[255:224]), 256'(cw(61)));
    drain();

    // R11 commit and pop when full
    for (int n = 70; n < 70 + N; n++) step(1'b1, 3'd7, cw(n), 1'b0);
    step(1'b1, 3'd7, cw(80), 1'b1);
    chk("R11 level", 256'(level), 256'(N - 1));
    chk("R11 drop", 256'(drop), 256'(1));
    drain();

    // sweep every level with every commit/pop combination
    for (int lv = 0; lv <= N; lv++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < lv; k++) begin
          load(100 + k);
          step(1'b1, 3'd7, cw(100 + k), 1'b0);
        end
        step(op[0], 3'd7, cw(200 + op), op[1]);
        drain();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule